// File: doc/BRIEF.md
# Multi-Master Arbitration Tracker

This block sits beside a two-wire serial bus master and watches the bus while the local master transmits. On each rising edge of the clock line it compares the line's data level with the bit the local master is driving. When the local master released the data line but sees it held low, another master has won. The tracker then tells the master to release its data drive and decides how the node goes on from there.

A loss in the data bytes makes the node a non-addressed listener at once. A loss inside the first byte after a START (the seven address bits or the direction bit) does not end the node's part in the transfer. The tracker keeps shifting in the winner's address byte and checks it against the node's own address and, when enabled, against the general-call address. It then takes the slave-receive role, takes the slave-transmit role, or stays a non-addressed listener. Each outcome loads its own 8-bit status code together with a one-clock strobe. When a STOP frees the bus, every role is dropped. If the software option for a retry is set, the tracker also asks the master for a new START.

Both bus lines are expected as clean signals that are already synchronous to `clk`. Clock stretching, bit-rate generation and the data shifter of the master are not part of this block.

Top module: `arb_track`

## Requirements
- R1: During and after a synchronous reset `status` is 0xF8, and `status_vld`, `release_sda`, `slv_rx`, `slv_tx` and `start_req` are all 0.
- R2: A loss is detected on an SCL rising edge when the bus is busy, `tx_active` is 1, `tx_bit` is 1, SDA is 0 and the edge is one of the eight data-carrying bit slots of a byte. `release_sda` goes to 1 one clock after that edge, while SCL is still high, and stays at 1 until a STOP.
- R3: No loss is flagged when SDA equals `tx_bit`, when `tx_active` is 0, or on the ninth (acknowledge) SCL edge of a byte, even with `tx_bit`=1 and SDA=0.
- R4: A loss in any byte after the first loads status 0x38 one clock after the losing edge, and no slave role is taken.
- R5: Bytes are sent most-significant bit first. The first seven bits after a START form the address and the eighth is the direction bit (1 = read). After a loss in the first byte, an address equal to `own_addr` with direction write loads status 0x68 and sets `slv_rx`. Both take effect one clock after the eighth SCL rising edge.
- R6: After a loss in the first byte, an address equal to `own_addr` with direction read loads status 0xB0 and sets `slv_tx`.
- R7: After a loss in the first byte, the all-zero address with direction write loads status 0x78 and sets `slv_rx` when `gc_en` is 1. With `gc_en` at 0, or with direction read, it loads 0x38 instead.
- R8: After a loss in the first byte, any other address loads status 0x38 and neither `slv_rx` nor `slv_tx` is set.
- R9: A loss on the direction bit itself is decided from the same byte on the same edge, so status and role appear one clock after that eighth edge.
- R10: A STOP (SDA rising while SCL is high) clears `release_sda`, `slv_rx` and `slv_tx` one clock after the rising SDA edge. If the node had lost arbitration and `rejoin_en` is 1, `start_req` pulses for exactly one clock. Otherwise it stays at 0.
- R11: `status_vld` is high for one clock per status load, only with one of 0x38, 0x68, 0x78 or 0xB0, and `status` holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled clock line level |
| sda_i | input | 1 | Sampled data line level |
| tx_active | input | 1 | Local master is driving the current bit |
| tx_bit | input | 1 | Bit the local master drives (1 = released) |
| own_addr | input | ADDR_W | Node's own slave address |
| gc_en | input | 1 | Answer the general-call address |
| rejoin_en | input | 1 | Request a new START once the bus is free after a loss |
| release_sda | output | 1 | Local data drive must be released |
| slv_rx | output | 1 | Node is the addressed slave receiver |
| slv_tx | output | 1 | Node is the addressed slave transmitter |
| status | output | 8 | Last loaded status code |
| status_vld | output | 1 | One-clock strobe on each status load |
| start_req | output | 1 | One-clock request for a new START |

## Verification
A bit counter that has slipped by one slot moves the decision to the wrong edge. The address check then runs on a shifted byte, so the port shows the wrong status code or role one clock after the eighth edge. Slipping the other way also makes the acknowledge slot look like a loss. A wrong state after a loss shows at the ports within one clock: `release_sda` drops early, a role appears without a strobe, or `start_req` fires at a STOP that should be silent. The bench therefore checks the code and role after every address outcome, the timing of the release inside the losing high phase, and the outputs right after each STOP.

// File: rtl/arb_trk_pkg.sv
package arb_trk_pkg;

  localparam int STAT_W = 8;

  localparam logic [STAT_W-1:0] CODE_IDLE        = 8'hF8;
  localparam logic [STAT_W-1:0] CODE_LOST_NOADDR = 8'h38;
  localparam logic [STAT_W-1:0] CODE_LOST_SRX    = 8'h68;
  localparam logic [STAT_W-1:0] CODE_LOST_GCALL  = 8'h78;
  localparam logic [STAT_W-1:0] CODE_LOST_STX    = 8'hB0;

  typedef enum logic [2:0] {
    TS_IDLE   = 3'd0,
    TS_BUSY   = 3'd1,
    TS_LISTEN = 3'd2,
    TS_SRX    = 3'd3,
    TS_STX    = 3'd4,
    TS_NAS    = 3'd5
  } trk_state_e;

  typedef struct packed {
    trk_state_e          nxt;
    logic [STAT_W-1:0]   code;
  } verdict_t;

endpackage

// File: rtl/arb_bus_cond.sv
module arb_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/arb_bit_track.sv
module arb_bit_track #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              start_det,
  output logic              in_first,
  output logic              last_bit,
  output logic              ack_slot,
  output logic [BYTE_W-1:0] byte_next
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_idx;
  logic [BYTE_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx  <= '0;
      in_first <= 1'b0;
      shreg    <= '0;
    end else if (start_det) begin
      bit_idx  <= '0;
      in_first <= 1'b1;
    end else if (scl_rise) begin
      if (bit_idx == ACK_IDX) begin
        bit_idx  <= '0;
        in_first <= 1'b0;
      end else begin
        bit_idx <= bit_idx + 1'b1;
        shreg   <= {shreg[BYTE_W-3:0], sda_i};
      end
    end
  end

  always_comb begin
    ack_slot  = (bit_idx == ACK_IDX);
    last_bit  = (bit_idx == LAST_IDX);
    byte_next = {shreg, sda_i};
  end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_trk_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              in_first,
  input  logic              last_bit,
  input  logic              ack_slot,
  input  logic [ADDR_W:0]   byte_next,
  input  logic              tx_active,
  input  logic              tx_bit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              rejoin_en,
  output logic              release_sda,
  output logic              slv_rx,
  output logic              slv_tx,
  output logic              bus_busy,
  output logic [STAT_W-1:0] status,
  output logic              status_vld,
  output logic              start_req
);
  localparam logic [ADDR_W-1:0] GC_ADDR = '0;

  trk_state_e st;
  logic       lose;
  logic       lost_any;
  verdict_t   verdict;

  function automatic verdict_t judge(input logic [ADDR_W:0] b,
                                     input logic [ADDR_W-1:0] own,
                                     input logic gce);
    verdict_t v;
    logic [ADDR_W-1:0] a;
    logic rd;
    a  = b[ADDR_W:1];
    rd = b[0];
    if (a == own && !rd) begin
      v.nxt  = TS_SRX;
      v.code = CODE_LOST_SRX;
    end else if (a == own && rd) begin
      v.nxt  = TS_STX;
      v.code = CODE_LOST_STX;
    end else if (a == GC_ADDR && !rd && gce) begin
      v.nxt  = TS_SRX;
      v.code = CODE_LOST_GCALL;
    end else begin
      v.nxt  = TS_NAS;
      v.code = CODE_LOST_NOADDR;
    end
    return v;
  endfunction

  always_comb begin
    lose     = scl_rise && (st == TS_BUSY) && tx_active && tx_bit &&
               !sda_i && !ack_slot;
    lost_any = (st == TS_LISTEN) || (st == TS_SRX) ||
               (st == TS_STX) || (st == TS_NAS);
    verdict  = judge(byte_next, own_addr, gc_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= TS_IDLE;
      status     <= CODE_IDLE;
      status_vld <= 1'b0;
      start_req  <= 1'b0;
    end else begin
      status_vld <= 1'b0;
      start_req  <= 1'b0;
      if (stop_det) begin
        start_req <= lost_any && rejoin_en;
        st        <= TS_IDLE;
      end else if (start_det) begin
        if (st == TS_IDLE) st <= TS_BUSY;
      end else begin
        unique case (st)
          TS_BUSY: begin
            if (lose) begin
              if (!in_first) begin
                st         <= TS_NAS;
                status     <= CODE_LOST_NOADDR;
                status_vld <= 1'b1;
              end else if (last_bit) begin
                st         <= verdict.nxt;
                status     <= verdict.code;
                status_vld <= 1'b1;
              end else begin
                st <= TS_LISTEN;
              end
            end
          end
          TS_LISTEN: begin
            if (scl_rise && in_first && last_bit) begin
              st         <= verdict.nxt;
              status     <= verdict.code;
              status_vld <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    release_sda = lost_any;
    slv_rx      = (st == TS_SRX);
    slv_tx      = (st == TS_STX);
    bus_busy    = (st == TS_BUSY);
  end
endmodule

// File: rtl/arb_track.sv
module arb_track
  import arb_trk_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              tx_active,
  input  logic              tx_bit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              rejoin_en,
  output logic              release_sda,
  output logic              slv_rx,
  output logic              slv_tx,
  output logic [STAT_W-1:0] status,
  output logic              status_vld,
  output logic              start_req
);
  localparam int BYTE_W = ADDR_W + 1;

  logic              scl_rise;
  logic              start_det;
  logic              stop_det;
  logic              in_first;
  logic              last_bit;
  logic              ack_slot;
  logic              bus_busy;
  logic [BYTE_W-1:0] byte_next;

  arb_bus_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  arb_bit_track #(.BYTE_W(BYTE_W)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .in_first  (in_first),
    .last_bit  (last_bit),
    .ack_slot  (ack_slot),
    .byte_next (byte_next)
  );

  arb_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sda_i       (sda_i),
    .scl_rise    (scl_rise),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .in_first    (in_first),
    .last_bit    (last_bit),
    .ack_slot    (ack_slot),
    .byte_next   (byte_next),
    .tx_active   (tx_active),
    .tx_bit      (tx_bit),
    .own_addr    (own_addr),
    .gc_en       (gc_en),
    .rejoin_en   (rejoin_en),
    .release_sda (release_sda),
    .slv_rx      (slv_rx),
    .slv_tx      (slv_tx),
    .bus_busy    (bus_busy),
    .status      (status),
    .status_vld  (status_vld),
    .start_req   (start_req)
  );
endmodule

// File: rtl/arb_track_chk.sv
module arb_track_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_i,
  input logic       tx_active,
  input logic       tx_bit,
  input logic       ack_slot,
  input logic       bus_busy,
  input logic       rejoin_en,
  input logic       release_sda,
  input logic       slv_rx,
  input logic       slv_tx,
  input logic [7:0] status,
  input logic       status_vld,
  input logic       start_req
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && tx_active && tx_bit && !sda_i && scl_i && !scl_q && !ack_slot)
      |=> release_sda); // R2
  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (release_sda && !(scl_i && scl_q && sda_i && !sda_q)) |=> release_sda); // R10
  AST_ROLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(slv_rx && slv_tx)); // R6
  AST_ROLE_AFTER_LOSS: assert property (@(posedge clk) disable iff (rst)
    (slv_rx || slv_tx) |-> release_sda); // R5
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    status_vld |=> !status_vld); // R11
  AST_VLD_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    status_vld |-> (status == 8'h38 || status == 8'h68 ||
                    status == 8'h78 || status == 8'hB0)); // R11
  AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    !status_vld |-> $stable(status)); // R11
  AST_START_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_req |=> !start_req); // R10
  AST_START_REQ_OPTION: assert property (@(posedge clk) disable iff (rst)
    start_req |-> $past(rejoin_en)); // R10
endmodule

bind arb_track arb_track_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .tx_active   (tx_active),
  .tx_bit      (tx_bit),
  .ack_slot    (ack_slot),
  .bus_busy    (bus_busy),
  .rejoin_en   (rejoin_en),
  .release_sda (release_sda),
  .slv_rx      (slv_rx),
  .slv_tx      (slv_tx),
  .status      (status),
  .status_vld  (status_vld),
  .start_req   (start_req)
);

// File: tb/arb_track_test.sv
module arb_track_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] OWN = 7'h2A;

  typedef struct packed {
    logic [7:0] ours0;
    logic [7:0] oth0;
    logic [7:0] ours1;
    logic [7:0] oth1;
    logic       gc;
    logic       rejoin;
    logic       lost;
    logic       rx;
    logic       tx;
    logic [7:0] code;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{8'hA0, 8'hA0, 8'h55, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 no loss
    '{8'hA0, 8'hA0, 8'hF0, 8'hE0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h38}, // R4 data loss
    '{8'hA0, 8'h54, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h68}, // R5 own write
    '{8'hA0, 8'h55, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hB0}, // R6 own read
    '{8'hA0, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h78}, // R7 gc on
    '{8'hA0, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h38}, // R7 gc off
    '{8'hA0, 8'h80, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h38}, // R8 other
    '{8'h55, 8'h54, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h68}, // R9 rw bit
    '{8'hA0, 8'h01, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h38}, // R7 gc read
    '{8'h20, 8'hA0, 8'h00, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}  // R3 we win
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic tx_active = 1'b0;
  logic tx_bit = 1'b1;
  logic [ADDR_W-1:0] own_addr = OWN;
  logic gc_en = 1'b0;
  logic rejoin_en = 1'b0;
  logic release_sda, slv_rx, slv_tx, status_vld, start_req;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  int vld_cnt = 0;
  int req_cnt = 0;
  logic lost_m = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  arb_track #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .tx_active(tx_active), .tx_bit(tx_bit), .own_addr(own_addr),
    .gc_en(gc_en), .rejoin_en(rejoin_en), .release_sda(release_sda),
    .slv_rx(slv_rx), .slv_tx(slv_tx), .status(status),
    .status_vld(status_vld), .start_req(start_req)
  );

  always @(negedge clk) begin
    if (status_vld) vld_cnt++;
    if (start_req) req_cnt++;
  end

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_i = 1'b1; sda_i = 1'b1; wclk(3);
    sda_i = 1'b0; wclk(3);
    scl_i = 1'b0; wclk(2);
    lost_m = 1'b0;
  endtask

  task automatic bus_stop();
    tx_active = 1'b0;
    scl_i = 1'b0; sda_i = 1'b0; wclk(3);
    scl_i = 1'b1; wclk(3);
    sda_i = 1'b1; wclk(4);
  endtask

  task automatic send_bit(input logic ours, input logic oth, input logic act);
    scl_i = 1'b0;
    tx_active = act && !lost_m;
    tx_bit = ours;
    sda_i = (tx_active ? ours : 1'b1) & oth;
    wclk(3);
    scl_i = 1'b1;
    if (tx_active && ours && !oth) lost_m = 1'b1;
    wclk(4);
    scl_i = 1'b0; wclk(1);
  endtask

  task automatic send_ack();
    scl_i = 1'b0; tx_active = 1'b0; sda_i = 1'b0; wclk(3);
    scl_i = 1'b1; wclk(4);
    scl_i = 1'b0; wclk(1);
  endtask

  task automatic send_byte(input logic [7:0] ours, input logic [7:0] oth,
                           input logic act);
    for (int i = 7; i >= 0; i--) send_bit(ours[i], oth[i], act);
    send_ack();
  endtask

  task automatic do_reset();
    rst = 1'b1; wclk(3); rst = 1'b0; wclk(1);
  endtask

  task automatic check_reset_state();
    check("R1 status", status, 8'hF8);
    check("R1 vld", status_vld, 0);
    check("R1 release", release_sda, 0);
    check("R1 rx", slv_rx, 0);
    check("R1 tx", slv_tx, 0);
    check("R1 start_req", start_req, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wclk(2);
    check_reset_state(); // R1 while in reset
    do_reset();
    check_reset_state(); // R1 after release

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      gc_en = t.gc;
      rejoin_en = t.rejoin;
      vld_cnt = 0;
      req_cnt = 0;
      bus_start();
      send_byte(t.ours0, t.oth0, 1'b1);
      send_byte(t.ours1, t.oth1, 1'b1);
      check($sformatf("R2 release v%0d", v), release_sda, t.lost);
      check($sformatf("R11 strobes v%0d", v), vld_cnt, t.lost);
      if (t.lost) check($sformatf("R5 R6 R7 R8 R4 code v%0d", v), status, t.code);
      check($sformatf("R5 R7 slv_rx v%0d", v), slv_rx, t.rx);
      check($sformatf("R6 slv_tx v%0d", v), slv_tx, t.tx);
      bus_stop();
      check($sformatf("R10 release clr v%0d", v), release_sda, 0);
      check($sformatf("R10 roles clr v%0d", v), slv_rx | slv_tx, 0);
      check($sformatf("R10 start_req v%0d", v), req_cnt, t.lost && t.rejoin);
    end

    // R3: tx_active low with conflicting levels
    vld_cnt = 0;
    bus_start();
    send_byte(8'hFF, 8'h00, 1'b0);
    check("R3 inactive release", release_sda, 0);
    check("R3 inactive strobe", vld_cnt, 0);
    bus_stop();

    // R3: acknowledge slot is never an arbitration bit
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(1'b1 & (8'hA0 >> i), 1'b1, 1'b1);
    scl_i = 1'b0; tx_active = 1'b1; tx_bit = 1'b1; sda_i = 1'b0; wclk(3);
    scl_i = 1'b1; wclk(3);
    check("R3 ack slot", release_sda, 0);
    scl_i = 1'b0; wclk(1);
    bus_stop();

    // R2 timing inside the high phase, R10 no request without option
    rejoin_en = 1'b0;
    req_cnt = 0;
    bus_start();
    scl_i = 1'b0; tx_active = 1'b1; tx_bit = 1'b1; sda_i = 1'b0; wclk(3);
    scl_i = 1'b1; wclk(1);
    check("R2 same high phase", release_sda, 1);
    check("R2 scl still high", scl_i, 1);
    wclk(3); scl_i = 1'b0; wclk(1);
    bus_stop();
    check("R10 no request", req_cnt, 0);

    // R1: reset in the middle of a lost transfer
    gc_en = 1'b1;
    bus_start();
    send_byte(8'hA0, 8'h00, 1'b1);
    check("R7 before reset", status, 8'h78);
    do_reset();
    check_reset_state();
    scl_i = 1'b1; sda_i = 1'b1; wclk(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule